// File: doc/BRIEF.md
# SPI Slave Register Access Bridge

This block is an SPI slave that converts serial host transactions into single-cycle read and write requests on an internal byte-wide register bus with a 7-bit address. It runs entirely in the system clock domain. The SPI clock, chip-select and data-in lines are oversampled through two-flop synchronizers, and the block detects the SPI clock edges itself. The SPI mode has the clock idling low. The slave shifts data out after a rising SPI edge and samples incoming data on the falling edge, most significant bit first in both directions.

Every transaction opens with a 16-bit status word. The block captures it when select goes active and sends it back during the first two byte slots, high byte first. The first byte from the host is a command: bit 7 set means write, bit 7 clear means read, and bits 6:0 give the register address. In read mode, each further byte from the host with bit 7 clear is the next random read address. Read data for an address received in byte slot k is returned in slot k+2, and a slot that follows no read returns 0x00. A byte with bit 7 set starts a write burst. From then on, every byte is write data to an address that increments by one and wraps from 127 to 0. A freeze pulse at the start of each transaction tells the register block to take a consistent snapshot.

Deasserting select at any point aborts the transaction. The next transaction starts fresh with a new command byte.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, spi_miso_o, reg_rd_o, reg_wr_o and reg_freeze_o are all 0.
- R2: reg_freeze_o pulses high for exactly one system clock each time select goes active, and at no other time.
- R3: The first two bytes shifted out in a transaction are status_i as sampled when select became active: bits 15:8 first, then bits 7:0. A later change of status_i does not alter them.
- R4: spi_miso_o changes only after a rising SPI clock edge or a change of select. Bits travel MSB first and are taken from spi_mosi_i on falling SPI clock edges.
- R5: A command byte with bit 7 set issues no read strobe. A command byte with bit 7 clear issues exactly one read strobe, at the address in bits 6:0.
- R6: The read data for an address received in byte slot k is shifted out in slot k+2. A slot whose preceding byte was not a read address returns 0x00.
- R7: In a read sequence, every further byte with bit 7 clear is a new random read address and issues one read strobe at that address.
- R8: In a write burst, each data byte produces one write strobe. The address starts at the command address, increments by one per byte and wraps from 127 to 0.
- R9: Once a write burst has begun, every byte is write data, including bytes with bit 7 set.
- R10: A byte with bit 7 set during a read sequence switches the transaction to a write burst at the address in bits 6:0.
- R11: Deasserting select aborts the transaction. A partial byte issues no strobe, and the next transaction restarts at the command byte with status output.
- R12: reg_rd_o and reg_wr_o are each one system clock wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | SPI clock from host, idle low |
| spi_cs_n_i | input | 1 | SPI select from host, active low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host, 0 while deselected |
| status_i | input | 16 | Status word sent at the start of each transaction |
| reg_addr_o | output | 7 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_rdata_i | input | 8 | Register bus read data, valid the cycle after reg_rd_o |
| reg_rd_o | output | 1 | Read request strobe |
| reg_wr_o | output | 1 | Write request strobe |
| reg_freeze_o | output | 1 | Snapshot strobe at transaction start |

## Verification
A pin change reaches the outputs at the third rising system clock edge. Two edges go to the synchronizer and one to the state register, so strobes, freeze and the next data-out bit appear three cycles after the SPI edge or select change that causes them. Read data is taken from the register bus two cycles after the read request and is sent out one byte slot later. The bench master holds each SPI clock phase for twelve system clocks and samples data-out just before each falling edge. It checks strobe logs and counters only after a deselect gap of 24 cycles, so every result is due well inside the window in which it is checked.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int STAT_W = 2 * DATA_W;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_CMD,
        MODE_READ,
        MODE_WRITE
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [BIT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] slot;
        logic              miso;
        logic [ADDR_W-1:0] waddr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd;
        logic              wr;
        logic              frz;
        logic              rd_pend;
    } core_state_t;
endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/spi_bridge_edge.sv
module spi_bridge_edge #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_LVL;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_bridge_core.sv
module spi_bridge_core
    import spi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              start_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              miso_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              frz_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    core_state_t       st_d, st_q;
    logic [DATA_W-1:0] byte_in;

    always_comb begin
        st_d         = st_q;
        st_d.rd      = 1'b0;
        st_d.wr      = 1'b0;
        st_d.frz     = 1'b0;
        st_d.rd_pend = st_q.rd;
        byte_in      = {st_q.rx[DATA_W-2:0], mosi_i};
        if (st_q.rd_pend) st_d.slot = rdata_i;

        if (!active_i) begin
            st_d.mode   = MODE_IDLE;
            st_d.bitcnt = '0;
            st_d.miso   = 1'b0;
        end else if (start_i) begin
            st_d.mode   = MODE_CMD;
            st_d.bitcnt = '0;
            st_d.tx     = status_i[STAT_W-1 -: DATA_W];
            st_d.slot   = status_i[DATA_W-1:0];
            st_d.miso   = 1'b0;
            st_d.frz    = 1'b1;
        end else begin
            if (sck_rise_i) begin
                st_d.miso = st_q.tx[DATA_W-1];
                st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b0};
            end
            if (sck_fall_i) begin
                st_d.rx     = byte_in;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == LAST_BIT) begin
                    st_d.tx   = st_q.slot;
                    st_d.slot = '0;
                    if (st_q.mode == MODE_WRITE) begin
                        st_d.wr    = 1'b1;
                        st_d.addr  = st_q.waddr;
                        st_d.wdata = byte_in;
                        st_d.waddr = st_q.waddr + 1'b1;
                    end else if (byte_in[DATA_W-1]) begin
                        st_d.mode  = MODE_WRITE;
                        st_d.waddr = byte_in[ADDR_W-1:0];
                    end else begin
                        st_d.mode = MODE_READ;
                        st_d.rd   = 1'b1;
                        st_d.addr = byte_in[ADDR_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o  = st_q.miso;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign rd_o    = st_q.rd;
    assign wr_o    = st_q.wr;
    assign frz_o   = st_q.frz;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o)); // R12
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o); // R12
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o); // R12
    AST_FREEZE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frz_o |=> !frz_o); // R2
    AST_FREEZE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        frz_o |-> (st_q.mode == MODE_CMD && st_q.bitcnt == '0)); // R2
    AST_MISO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (miso_o == 1'b0)); // R11
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !start_i && !sck_rise_i) |=> $stable(miso_o)); // R4
    AST_WRITE_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (st_q.mode == MODE_WRITE)); // R9
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    input  logic [STAT_W-1:0] status_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic              reg_freeze_o
);
    localparam int SYNC_STAGES = 2;

    logic [2:0] pins_s;
    logic       cs_n_s, sck_s, mosi_s;
    logic       sck_rise, sck_fall, cs_rise, cs_fall;

    spi_bridge_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_cs_n_i, spi_sck_i, spi_mosi_i}),
        .sync_o (pins_s)
    );

    assign {cs_n_s, sck_s, mosi_s} = pins_s;

    spi_bridge_edge #(.RST_LVL(1'b0)) i_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (sck_s),
        .rise_o(sck_rise),
        .fall_o(sck_fall)
    );

    spi_bridge_edge #(.RST_LVL(1'b1)) i_cs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (cs_n_s),
        .rise_o(cs_rise),
        .fall_o(cs_fall)
    );

    spi_bridge_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (~cs_n_s),
        .start_i   (cs_fall),
        .sck_rise_i(sck_rise),
        .sck_fall_i(sck_fall),
        .mosi_i    (mosi_s),
        .status_i  (status_i),
        .rdata_i   (reg_rdata_i),
        .miso_o    (spi_miso_o),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .rd_o      (reg_rd_o),
        .wr_o      (reg_wr_o),
        .frz_o     (reg_freeze_o)
    );

    AST_DESELECT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !(reg_rd_o || reg_wr_o)); // R11
endmodule

// File: tb/test_spi_reg_bridge.sv
module test_spi_reg_bridge;
    localparam int HALF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] status = 16'h0000;
    logic [6:0]  raddr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        rd, wr, frz;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem [128];
    logic [6:0] wlog_a [64];
    logic [7:0] wlog_d [64];
    logic [6:0] rlog_a [64];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int frz_cnt = 0;

    always #2 clk = ~clk;

    spi_reg_bridge i_spi_reg_bridge (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck_i   (sck),
        .spi_cs_n_i  (cs_n),
        .spi_mosi_i  (mosi),
        .spi_miso_o  (miso),
        .status_i    (status),
        .reg_addr_o  (raddr),
        .reg_wdata_o (wdata),
        .reg_rdata_i (rdata),
        .reg_rd_o    (rd),
        .reg_wr_o    (wr),
        .reg_freeze_o(frz)
    );

    function automatic logic [7:0] pat(input logic [6:0] a);
        return {a[3:0], a[6:3]} ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= pat(7'(i));
            rdata <= 8'h00;
        end else begin
            if (wr) begin
                mem[raddr] <= wdata;
                if (wr_cnt < 64) begin
                    wlog_a[wr_cnt] <= raddr;
                    wlog_d[wr_cnt] <= wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end
            if (rd) begin
                rdata <= mem[raddr];
                if (rd_cnt < 64) rlog_a[rd_cnt] <= raddr;
                rd_cnt <= rd_cnt + 1;
            end
            if (frz) frz_cnt <= frz_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic select_off();
        sck = 1'b0;
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            sck  = 1'b1;
            wait_clk(HALF);
            rx[i] = miso;
            sck  = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        check(miso == 1'b0, "R1 miso", int'(miso), 0);
        check(!rd && !wr, "R1 strobes", int'({rd, wr}), 0);
        check(frz == 1'b0, "R1 freeze", int'(frz), 0);
    endtask

    task automatic t_status_and_reads();
        logic [7:0] b0, b1, b2, b3;
        int r0 = rd_cnt;
        int f0 = frz_cnt;
        status = 16'hC3A5;
        select_on();
        status = 16'h1234;
        xfer(8'h05, b0);
        xfer(8'h06, b1);
        xfer(8'h07, b2);
        xfer(8'h07, b3);
        select_off();
        check(b0 == 8'hC3, "R3 status high", b0, 8'hC3);
        check(b1 == 8'hA5, "R3 status low", b1, 8'hA5);
        check(b2 == pat(7'h05), "R6 first read data", b2, pat(7'h05));
        check(b3 == pat(7'h06), "R7 random read data", b3, pat(7'h06));
        check(rd_cnt - r0 == 4, "R5 R7 read strobe count", rd_cnt - r0, 4);
        check(rlog_a[r0] == 7'h05 && rlog_a[r0+1] == 7'h06 && rlog_a[r0+2] == 7'h07,
              "R7 read addresses", rlog_a[r0+1], 7'h06);
        check(frz_cnt - f0 == 1, "R2 freeze once", frz_cnt - f0, 1);
    endtask

    task automatic t_write_wrap();
        logic [7:0] b0, b1, b2, b3;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        status = 16'h5AF0;
        select_on();
        xfer(8'hFE, b0);
        xfer(8'h11, b1);
        xfer(8'h22, b2);
        xfer(8'h33, b3);
        select_off();
        check(b0 == 8'h5A && b1 == 8'hF0, "R3 status in write", {b0, b1}, 16'h5AF0);
        check(b2 == 8'h00 && b3 == 8'h00, "R6 no read data", {b2, b3}, 0);
        check(rd_cnt == r0, "R5 write cmd no read", rd_cnt - r0, 0);
        check(wr_cnt - w0 == 3, "R8 write count", wr_cnt - w0, 3);
        check(wlog_a[w0] == 7'h7E && wlog_d[w0] == 8'h11, "R8 first write", wlog_a[w0], 7'h7E);
        check(wlog_a[w0+1] == 7'h7F && wlog_d[w0+1] == 8'h22, "R8 increment", wlog_a[w0+1], 7'h7F);
        check(wlog_a[w0+2] == 7'h00 && wlog_d[w0+2] == 8'h33, "R8 wrap", wlog_a[w0+2], 7'h00);
    endtask

    task automatic t_write_high_bytes();
        logic [7:0] b;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        select_on();
        xfer(8'h90, b);
        xfer(8'h85, b);
        xfer(8'h02, b);
        select_off();
        check(wr_cnt - w0 == 2 && rd_cnt == r0, "R9 count", wr_cnt - w0, 2);
        check(wlog_a[w0] == 7'h10 && wlog_d[w0] == 8'h85, "R9 bit7 byte is data",
              wlog_d[w0], 8'h85);
        check(wlog_a[w0+1] == 7'h11 && wlog_d[w0+1] == 8'h02, "R9 next data",
              wlog_d[w0+1], 8'h02);
    endtask

    task automatic t_read_then_write();
        logic [7:0] b0, b1, b2, b3, b4;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        select_on();
        xfer(8'h20, b0);
        xfer(8'h21, b1);
        xfer(8'hB0, b2);
        xfer(8'h99, b3);
        xfer(8'h98, b4);
        select_off();
        check(b2 == pat(7'h20), "R10 read A data", b2, pat(7'h20));
        check(b3 == pat(7'h21), "R10 read B data", b3, pat(7'h21));
        check(b4 == 8'h00, "R6 slot after write cmd", b4, 0);
        check(rd_cnt - r0 == 2, "R10 reads", rd_cnt - r0, 2);
        check(wr_cnt - w0 == 2 && wlog_a[w0] == 7'h30 && wlog_d[w0] == 8'h99,
              "R10 write at cmd addr", wlog_a[w0], 7'h30);
        check(wlog_a[w0+1] == 7'h31 && wlog_d[w0+1] == 8'h98, "R10 second write",
              wlog_a[w0+1], 7'h31);
    endtask

    task automatic t_readback();
        logic [7:0] b0, b1, b2, b3, b4;
        select_on();
        xfer(8'h30, b0);
        xfer(8'h7E, b1);
        xfer(8'h00, b2);
        xfer(8'h00, b3);
        xfer(8'h00, b4);
        select_off();
        check(b2 == 8'h99, "R8 readback 0x30", b2, 8'h99);
        check(b3 == 8'h11, "R8 readback 0x7E", b3, 8'h11);
        check(b4 == 8'h33, "R8 readback 0x00 wrap", b4, 8'h33);
    endtask

    task automatic t_abort();
        logic [7:0] b0, b1, b2;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        int f0 = frz_cnt;
        status = 16'h8E71;
        select_on();
        xfer_bits(8'h80, 3, b0);
        select_off();
        check(wr_cnt == w0 && rd_cnt == r0, "R11 partial byte", wr_cnt + rd_cnt, w0 + r0);
        select_on();
        xfer(8'hC0, b0);
        select_off();
        select_on();
        xfer(8'h05, b0);
        xfer(8'h00, b1);
        xfer(8'h00, b2);
        select_off();
        check(b0 == 8'h8E && b1 == 8'h71, "R11 status after abort", {b0, b1}, 16'h8E71);
        check(b2 == pat(7'h05), "R11 realigned read", b2, pat(7'h05));
        check(wr_cnt == w0, "R11 write burst aborted", wr_cnt - w0, 0);
        check(rd_cnt - r0 == 3 && rlog_a[r0] == 7'h05, "R11 fresh command is read",
              rd_cnt - r0, 3);
        check(frz_cnt - f0 == 3, "R2 freeze per select", frz_cnt - f0, 3);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_status_and_reads();
        t_write_wrap();
        t_write_high_bytes();
        t_read_then_write();
        t_readback();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule